// File: doc/BRIEF.md
# USB host downstream port controller

This block sequences one downstream port of a USB host through its life cycle: disabled, bus reset, active, winding down, suspended and resuming. Software drives it through a three-bit control word (bus-reset, port-enable and resume bits) and a two-bit write-one-to-clear status word. Two event inputs from the link layer report a device detach and an end-of-frame error. The block tells the transceiver which line state to present, and while the port is active it emits a one-cycle start-of-frame strobe on every frame boundary together with an 11-bit frame number.

Frame timing is derived from the clock by a counter. The parameter `UFRAME_CYCLES` is the number of clock cycles in one 125 µs microframe. With `hs_mode` high the SOF period is `UFRAME_CYCLES`. With `hs_mode` low it is eight times that, which gives 1 ms. Packet encoding, the analog front end, data transfers and enumeration are handled elsewhere.

Encodings. Control word: bit 0 resume, bit 1 port enable, bit 2 bus reset. Status word: bit 0 detach seen, bit 1 end-of-frame error seen. `port_state`: 0 disabled, 1 bus reset, 2 active, 3 stopping, 4 suspended, 5 resuming. `line_state`: 0 released, 1 J, 2 K, 3 SE0.

Top module: `usb_dport_ctrl`

## Requirements
- R1: After reset the control word and the status word read 0, `port_state` is 0 (disabled), `line_state` is 0 (released), `frame_num` is 0 and `sof_pulse` is low.
- R2: While the bus-reset bit (bit 2) reads 1, `line_state` is 3 (SE0) and `port_state` is 1 (bus reset). The enable and resume bits read 0, and writes of 1 to them are ignored. `frame_num` is cleared to 0 while in bus reset.
- R3: A write of 1 to the enable bit (bit 1) takes effect only in two cases: the same write turns a 1 in the bus-reset bit into 0, or it turns a 1 in the resume bit into 0. Any other attempt to set the bit leaves it at 0. A bus-reset end with the enable bit left at 0 puts the port in state 0.
- R4: Once `port_state` becomes 2 (active), the first `sof_pulse` comes exactly P cycles later and every following one comes P cycles after the previous one. P is `UFRAME_CYCLES` with `hs_mode`=1 and 8×`UFRAME_CYCLES` with `hs_mode`=0. No strobe is issued outside states 2 and 3.
- R5: At full speed `frame_num` advances by one with every strobe and wraps from 2047 to 0. At high speed it advances only on every eighth strobe. The value seen together with the strobe is the already-advanced number.
- R6: Clearing the enable bit by software in state 2 moves the port to state 3 (stopping). Exactly one further strobe follows on the scheduled boundary, then the port enters state 4 (suspended) and issues no more strobes.
- R7: A write of 1 to the resume bit (bit 0) is ignored unless the port is suspended or already resuming.
- R8: `line_state` is 2 (K) in every cycle in which the resume bit reads 1. It leaves K in the cycle directly after the write that clears the bit.
- R9: Clearing the resume bit while setting the enable bit moves the port from state 5 to state 2 in the next cycle. Clearing the resume bit alone returns the port to state 4.
- R10: A detach event while the enable bit is 1 clears that bit and sends the port to state 0 with no further strobes.
- R11: An end-of-frame error event while the enable bit is 1 clears that bit and sends the port to state 0 with no further strobes.
- R12: Each event sets its status bit in any state. Writing 1 to a status bit clears it, except that an event arriving in the same cycle keeps the bit set.
- R13: `line_state` is 1 (J) in states 2, 3 and 4 when no resume is driven, and 0 (released) in state 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hs_mode | input | 1 | 1 selects 125 µs microframes, 0 selects 1 ms frames |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 3 | Control word: bit 2 bus reset, bit 1 enable, bit 0 resume |
| sts_we | input | 1 | Write strobe for status clearing |
| sts_wdata | input | 2 | Write-one-to-clear mask: bit 0 detach, bit 1 end-of-frame error |
| detach_evt | input | 1 | One-cycle detach event |
| eoferr_evt | input | 1 | One-cycle end-of-frame error event |
| ctl_rdata | output | 3 | Current control bits |
| sts_rdata | output | 2 | Sticky status bits |
| port_state | output | 3 | Port state code |
| line_state | output | 2 | Line-state request to the transceiver |
| sof_pulse | output | 1 | One-cycle start-of-frame strobe |
| frame_num | output | 11 | Current frame number |

## Verification
Several rules are checked on every cycle. The bus-reset bit excludes the other two bits, K appears only in states 4 or 5, and strobes come only from states 2 or 3. The frame number changes only with a strobe or after bus reset, the active state is entered only from a legal predecessor, an event clears the enable bit on the next cycle, and a strobe is never late. The exact strobe spacing, the high-speed divide-by-eight of the frame number, the 2047 wrap, the single strobe while stopping, the ignored resume and enable writes, and the set-wins priority on status clears all depend on sequences of writes and events. Only the bench's scenarios can show those.

// File: rtl/usb_dport_pkg.sv
// Shared types and field positions for the downstream port controller.
// Assumes: field positions are fixed by software, codes by the transceiver.
package usb_dport_pkg;

    localparam int CTL_W         = 3;
    localparam int STS_W         = 2;
    localparam int CTL_RSM       = 0;
    localparam int CTL_EN        = 1;
    localparam int CTL_RST       = 2;
    localparam int FLG_DET       = 0;
    localparam int FLG_EOF       = 1;
    localparam int FRAME_W       = 11;
    localparam int UF_PER_FRAME  = 8;
    localparam int UF_W          = $clog2(UF_PER_FRAME);

    typedef enum logic [2:0] {
        PS_DISABLED  = 3'd0,
        PS_BUSRESET  = 3'd1,
        PS_ACTIVE    = 3'd2,
        PS_STOPPING  = 3'd3,
        PS_SUSPENDED = 3'd4,
        PS_RESUMING  = 3'd5
    } port_state_e;

    typedef enum logic [1:0] {
        LS_RELEASE = 2'd0,
        LS_J       = 2'd1,
        LS_K       = 2'd2,
        LS_SE0     = 2'd3
    } line_state_e;

endpackage

// File: rtl/dport_ctrl_regs.sv
// Control bits and sticky status flags of the port.
// Applies the legality rules for the enable and resume bits, forces them low
// during bus reset, and drops enable on a fault event.
// Assumes: events are one-cycle pulses; state is the registered port state.
module dport_ctrl_regs
    import usb_dport_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             sts_we,
    input  logic [STS_W-1:0] sts_wdata,
    input  logic             detach_evt,
    input  logic             eoferr_evt,
    input  port_state_e      state,
    output logic             rst_bit,
    output logic             en_bit,
    output logic             rsm_bit,
    output logic             drop_pulse,
    output logic [STS_W-1:0] flags
);

    logic             rst_d, en_d, rsm_d;
    logic             reset_end, resume_end, fault;
    logic [STS_W-1:0] flags_d;
    logic [STS_W-1:0] evt_vec;

    // Fault: an event while the port is enabled.
    assign fault   = (detach_evt || eoferr_evt) && en_bit;
    assign evt_vec = {eoferr_evt, detach_evt};

    // Next values of the control bits from a write and from faults.
    always_comb begin
        rst_d      = rst_bit;
        en_d       = en_bit;
        rsm_d      = rsm_bit;
        reset_end  = 1'b0;
        resume_end = 1'b0;
        if (ctl_we) begin
            rst_d      = ctl_wdata[CTL_RST];
            reset_end  = rst_bit && !ctl_wdata[CTL_RST];
            resume_end = rsm_bit && !ctl_wdata[CTL_RSM];
            if (ctl_wdata[CTL_RST]) begin
                en_d  = 1'b0;
                rsm_d = 1'b0;
            end else begin
                rsm_d = ctl_wdata[CTL_RSM] &&
                        (rsm_bit || state == PS_SUSPENDED);
                en_d  = ctl_wdata[CTL_EN] &&
                        (en_bit || reset_end || resume_end);
            end
        end
        if (fault) begin
            en_d = 1'b0;
        end
    end

    // Next value of the sticky flags: an event wins over a clear.
    always_comb begin
        flags_d = flags;
        if (sts_we) begin
            flags_d = flags & ~sts_wdata;
        end
        flags_d = flags_d | evt_vec;
    end

    // Register update of control bits, flags and the fault marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_bit    <= 1'b0;
            en_bit     <= 1'b0;
            rsm_bit    <= 1'b0;
            drop_pulse <= 1'b0;
            flags      <= '0;
        end else begin
            rst_bit    <= rst_d;
            en_bit     <= en_d;
            rsm_bit    <= rsm_d;
            drop_pulse <= fault;
            flags      <= flags_d;
        end
    end

endmodule

// File: rtl/dport_port_fsm.sv
// Port state sequencer. Follows the registered control bits one cycle later
// and decides when the frame timer runs.
// Assumes: drop_pulse marks a hardware-cleared enable; frame_tick is the
// timer's boundary in the current cycle.
module dport_port_fsm
    import usb_dport_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rst_bit,
    input  logic        en_bit,
    input  logic        rsm_bit,
    input  logic        drop_pulse,
    input  logic        frame_tick,
    output port_state_e state,
    output logic        run
);

    port_state_e state_d;

    // Timer runs while the port is active or finishing its last frame.
    always_comb begin
        run = 1'b0;
        if (!rst_bit) begin
            run = (state == PS_ACTIVE && !drop_pulse) ||
                  (state == PS_STOPPING);
        end
    end

    // Next-state decision.
    always_comb begin
        state_d = state;
        if (rst_bit) begin
            state_d = PS_BUSRESET;
        end else begin
            case (state)
                PS_BUSRESET:  state_d = en_bit ? PS_ACTIVE : PS_DISABLED;
                PS_ACTIVE: begin
                    if (drop_pulse)       state_d = PS_DISABLED;
                    else if (!en_bit)     state_d = frame_tick ? PS_SUSPENDED
                                                               : PS_STOPPING;
                end
                PS_STOPPING:  if (frame_tick) state_d = PS_SUSPENDED;
                PS_SUSPENDED: begin
                    if (rsm_bit)          state_d = PS_RESUMING;
                    else if (en_bit)      state_d = PS_ACTIVE;
                end
                PS_RESUMING:  if (!rsm_bit) state_d = en_bit ? PS_ACTIVE
                                                             : PS_SUSPENDED;
                default:      state_d = state;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PS_DISABLED;
        else        state <= state_d;
    end

endmodule

// File: rtl/dport_sof_timer.sv
// Frame divider and frame-number counter.
// Divides the clock to one (micro)frame, strobes SOF on each boundary and
// advances the 11-bit frame number (every eighth microframe at high speed).
// Assumes: hs_mode only changes while the timer is stopped.
module dport_sof_timer
    import usb_dport_pkg::*;
#(
    parameter int UFRAME_CYCLES = 15625
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               hs_mode,
    input  logic               clear_num,
    output logic               tick,
    output logic               sof_pulse,
    output logic [FRAME_W-1:0] frame_num
);

    localparam int FS_CYCLES = UFRAME_CYCLES * UF_PER_FRAME;
    localparam int CNT_W     = $clog2(FS_CYCLES);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;
    logic [UF_W-1:0]  uf_idx;

    // Terminal count for the selected speed.
    assign last = hs_mode ? CNT_W'(UFRAME_CYCLES - 1) : CNT_W'(FS_CYCLES - 1);
    assign tick = run && (cnt == last);

    // Cycle counter within the current (micro)frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end

    // SOF strobe, one cycle per boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) sof_pulse <= 1'b0;
        else        sof_pulse <= tick;
    end

    // Frame number and microframe index.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_num) begin
            frame_num <= '0;
            uf_idx    <= '0;
        end else if (tick) begin
            if (hs_mode) begin
                uf_idx <= uf_idx + 1'b1;
                if (uf_idx == UF_W'(UF_PER_FRAME - 1)) begin
                    frame_num <= frame_num + 1'b1;
                end
            end else begin
                uf_idx    <= '0;
                frame_num <= frame_num + 1'b1;
            end
        end
    end

endmodule

// File: rtl/usb_dport_ctrl.sv
// Top of the downstream port controller: control registers, port sequencer,
// frame timer and line-state encoder.
// Assumes: UFRAME_CYCLES is the clock count of 125 us; inputs are synchronous.
module usb_dport_ctrl
    import usb_dport_pkg::*;
#(
    parameter int UFRAME_CYCLES = 15625
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hs_mode,
    input  logic               ctl_we,
    input  logic [CTL_W-1:0]   ctl_wdata,
    input  logic               sts_we,
    input  logic [STS_W-1:0]   sts_wdata,
    input  logic               detach_evt,
    input  logic               eoferr_evt,
    output logic [CTL_W-1:0]   ctl_rdata,
    output logic [STS_W-1:0]   sts_rdata,
    output logic [2:0]         port_state,
    output logic [1:0]         line_state,
    output logic               sof_pulse,
    output logic [FRAME_W-1:0] frame_num
);

    logic        rst_bit, en_bit, rsm_bit, drop_pulse;
    logic        run, tick;
    port_state_e state;
    line_state_e line_d;

    dport_ctrl_regs i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_we     (ctl_we),
        .ctl_wdata  (ctl_wdata),
        .sts_we     (sts_we),
        .sts_wdata  (sts_wdata),
        .detach_evt (detach_evt),
        .eoferr_evt (eoferr_evt),
        .state      (state),
        .rst_bit    (rst_bit),
        .en_bit     (en_bit),
        .rsm_bit    (rsm_bit),
        .drop_pulse (drop_pulse),
        .flags      (sts_rdata)
    );

    dport_port_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_bit    (rst_bit),
        .en_bit     (en_bit),
        .rsm_bit    (rsm_bit),
        .drop_pulse (drop_pulse),
        .frame_tick (tick),
        .state      (state),
        .run        (run)
    );

    dport_sof_timer #(
        .UFRAME_CYCLES (UFRAME_CYCLES)
    ) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .hs_mode    (hs_mode),
        .clear_num  (state == PS_BUSRESET),
        .tick       (tick),
        .sof_pulse  (sof_pulse),
        .frame_num  (frame_num)
    );

    // Line-state request: SE0 in reset, K while resuming, idle otherwise.
    always_comb begin
        if (rst_bit)                   line_d = LS_SE0;
        else if (rsm_bit)              line_d = LS_K;
        else if (state == PS_DISABLED) line_d = LS_RELEASE;
        else                           line_d = LS_J;
    end

    assign line_state = line_d;
    assign port_state = state;
    assign ctl_rdata  = {rst_bit, en_bit, rsm_bit};

endmodule

// File: rtl/dport_checker.sv
// Cycle-by-cycle protocol checks for usb_dport_ctrl, attached by bind.
// Assumes: hs_mode is stable while the port is running.
module dport_checker
    import usb_dport_pkg::*;
#(
    parameter int UFRAME_CYCLES = 15625
) (
    input logic               clk,
    input logic               rst_n,
    input logic               hs_mode,
    input logic               detach_evt,
    input logic               eoferr_evt,
    input logic [CTL_W-1:0]   ctl_rdata,
    input logic [STS_W-1:0]   sts_rdata,
    input logic [2:0]         port_state,
    input logic [1:0]         line_state,
    input logic               sof_pulse,
    input logic [FRAME_W-1:0] frame_num
);

    localparam int FS_CYCLES = UFRAME_CYCLES * UF_PER_FRAME;

    int gap_cnt;
    int gap_lim;

    assign gap_lim = hs_mode ? UFRAME_CYCLES : FS_CYCLES;

    // Cycles spent running since the last strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || sof_pulse ||
            !(port_state == PS_ACTIVE || port_state == PS_STOPPING))
            gap_cnt <= 0;
        else
            gap_cnt <= gap_cnt + 1;
    end

    AST_RESET_EXCLUDES: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[CTL_RST] |-> (ctl_rdata[CTL_EN] == 1'b0 && ctl_rdata[CTL_RSM] == 1'b0 && line_state == LS_SE0)); // R2
    AST_K_WHEN_RESUMING: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == LS_K) |-> (port_state == PS_SUSPENDED || port_state == PS_RESUMING)); // R8
    AST_SOF_FROM_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |-> ($past(port_state) == PS_ACTIVE || $past(port_state) == PS_STOPPING)); // R4
    AST_SOF_NOT_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        gap_cnt <= gap_lim); // R4
    AST_FRAME_MOVES_ON_SOF: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_num != $past(frame_num)) |-> (sof_pulse || $past(port_state) == PS_BUSRESET)); // R5
    AST_ACTIVE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (port_state == PS_ACTIVE && $past(port_state) != PS_ACTIVE) |->
        ($past(port_state) == PS_BUSRESET || $past(port_state) == PS_RESUMING ||
         $past(port_state) == PS_SUSPENDED)); // R9
    AST_DETACH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (detach_evt && ctl_rdata[CTL_EN]) |=> !ctl_rdata[CTL_EN]); // R10
    AST_EOFERR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (eoferr_evt && ctl_rdata[CTL_EN]) |=> !ctl_rdata[CTL_EN]); // R11
    AST_FLAGS_STICK: assert property (@(posedge clk) disable iff (!rst_n)
        (detach_evt || eoferr_evt) |=> ((sts_rdata & {$past(eoferr_evt), $past(detach_evt)}) == {$past(eoferr_evt), $past(detach_evt)})); // R12

endmodule

bind usb_dport_ctrl dport_checker #(
    .UFRAME_CYCLES (UFRAME_CYCLES)
) i_dport_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .hs_mode    (hs_mode),
    .detach_evt (detach_evt),
    .eoferr_evt (eoferr_evt),
    .ctl_rdata  (ctl_rdata),
    .sts_rdata  (sts_rdata),
    .port_state (port_state),
    .line_state (line_state),
    .sof_pulse  (sof_pulse),
    .frame_num  (frame_num)
);

// File: tb/test_usb_dport_ctrl.sv
// Self-checking bench: a walked table of control writes, then directed tests.
module test_usb_dport_ctrl;

    localparam int UF  = 4;
    localparam int PFS = UF * 8;
    localparam int PHS = UF;

    localparam logic [2:0] S_DIS = 3'd0, S_RST = 3'd1, S_ACT = 3'd2,
                           S_STP = 3'd3, S_SUS = 3'd4, S_RSM = 3'd5;
    localparam logic [1:0] L_REL = 2'd0, L_J = 2'd1, L_K = 2'd2, L_SE0 = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hs_mode = 1'b0;
    logic        ctl_we = 1'b0;
    logic [2:0]  ctl_wdata = '0;
    logic        sts_we = 1'b0;
    logic [1:0]  sts_wdata = '0;
    logic        detach_evt = 1'b0;
    logic        eoferr_evt = 1'b0;
    logic [2:0]  ctl_rdata;
    logic [1:0]  sts_rdata;
    logic [2:0]  port_state;
    logic [1:0]  line_state;
    logic        sof_pulse;
    logic [10:0] frame_num;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    usb_dport_ctrl #(.UFRAME_CYCLES(UF)) i_usb_dport_ctrl (
        .clk(clk), .rst_n(rst_n), .hs_mode(hs_mode),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .sts_we(sts_we), .sts_wdata(sts_wdata),
        .detach_evt(detach_evt), .eoferr_evt(eoferr_evt),
        .ctl_rdata(ctl_rdata), .sts_rdata(sts_rdata),
        .port_state(port_state), .line_state(line_state),
        .sof_pulse(sof_pulse), .frame_num(frame_num)
    );

    // Table row: {write data, expected ctl, expected state, expected line, req}
    localparam int NVEC = 10;
    localparam logic [14:0] VEC [NVEC] = '{
        {3'b100, 3'b100, S_RST, L_SE0, 4'd2},  // R2 enter bus reset
        {3'b111, 3'b100, S_RST, L_SE0, 4'd2},  // R2 enable/resume ignored
        {3'b000, 3'b000, S_DIS, L_REL, 4'd3},  // R3 reset end without enable
        {3'b010, 3'b000, S_DIS, L_REL, 4'd3},  // R3 illegal enable
        {3'b001, 3'b000, S_DIS, L_REL, 4'd7},  // R7 resume while disabled
        {3'b100, 3'b100, S_RST, L_SE0, 4'd2},  // R2
        {3'b010, 3'b010, S_ACT, L_J,   4'd3},  // R3 legal enable, R13 J
        {3'b011, 3'b010, S_ACT, L_J,   4'd7},  // R7 resume while active
        {3'b110, 3'b100, S_RST, L_SE0, 4'd2},  // R2 reset from active
        {3'b010, 3'b010, S_ACT, L_J,   4'd13}  // R13
    };

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic ctl_write(input logic [2:0] d);
        ctl_wdata = d;
        ctl_we    = 1'b1;
        @(negedge clk);
        ctl_we    = 1'b0;
    endtask

    task automatic wait_sof(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sof_pulse && n < 2000);
    endtask

    task automatic count_sof(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (sof_pulse) n++;
        end
    endtask

    task automatic bring_up();
        ctl_write(3'b100);
        ctl_write(3'b010);
        while (port_state != S_ACT) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "ctl", ctl_rdata, 0);
        check("R1", "sts", sts_rdata, 0);
        check("R1", "state", port_state, S_DIS);
        check("R1", "line", line_state, L_REL);
        check("R1", "frame", frame_num, 0);
        check("R1", "sof", sof_pulse, 0);

        for (int v = 0; v < NVEC; v++) begin
            ctl_write(VEC[v][14:12]);
            @(negedge clk);
            check($sformatf("R%0d", VEC[v][3:0]), $sformatf("row%0d ctl", v),
                  ctl_rdata, VEC[v][11:9]);
            check($sformatf("R%0d", VEC[v][3:0]), $sformatf("row%0d state", v),
                  port_state, VEC[v][8:6]);
            check($sformatf("R%0d", VEC[v][3:0]), $sformatf("row%0d line", v),
                  line_state, VEC[v][5:4]);
        end

        // R4, R5: full-speed spacing and frame number
        bring_up();
        wait_sof(n);
        check("R4", "fs first gap", n, PFS);
        check("R5", "fs first frame", frame_num, 1);
        wait_sof(n);
        check("R4", "fs period", n, PFS);
        check("R5", "fs second frame", frame_num, 2);

        // R5: full-speed wrap 2047 -> 0
        bring_up();
        for (int k = 1; k <= 2048; k++) begin
            wait_sof(n);
            if (k == 2047) check("R5", "frame before wrap", frame_num, 2047);
            if (k == 2048) check("R5", "frame after wrap", frame_num, 0);
        end

        // R4, R5: high speed
        ctl_write(3'b100);
        hs_mode = 1'b1;
        bring_up();
        wait_sof(n);
        check("R4", "hs first gap", n, PHS);
        for (int k = 2; k <= 8; k++) begin
            wait_sof(n);
            if (k == 7) check("R5", "hs frame after 7", frame_num, 0);
            if (k == 8) begin
                check("R4", "hs period", n, PHS);
                check("R5", "hs frame after 8", frame_num, 1);
            end
        end
        ctl_write(3'b100);
        hs_mode = 1'b0;

        // R6: graceful stop
        bring_up();
        wait_sof(n);
        repeat (5) @(negedge clk);
        ctl_write(3'b000);
        @(negedge clk);
        check("R6", "stopping state", port_state, S_STP);
        count_sof(3 * PFS, n);
        check("R6", "one last sof", n, 1);
        check("R6", "suspended", port_state, S_SUS);
        check("R13", "idle J in suspend", line_state, L_J);

        // R8, R9: resume signalling
        ctl_write(3'b001);
        check("R8", "K on resume", line_state, L_K);
        repeat (10) @(negedge clk);
        check("R8", "K held", line_state, L_K);
        check("R9", "resuming", port_state, S_RSM);
        ctl_write(3'b000);
        check("R8", "K released", line_state, L_J);
        @(negedge clk);
        check("R9", "back to suspend", port_state, S_SUS);
        ctl_write(3'b001);
        repeat (3) @(negedge clk);
        ctl_write(3'b010);
        check("R8", "K off at resume end", line_state, L_J);
        @(negedge clk);
        check("R9", "active after resume", port_state, S_ACT);
        check("R3", "enable after resume", ctl_rdata, 3'b010);
        wait_sof(n);
        check("R4", "first sof after resume", n, PFS);

        // R10: detach drops the port
        detach_evt = 1'b1;
        @(negedge clk);
        detach_evt = 1'b0;
        @(negedge clk);
        check("R10", "enable cleared", ctl_rdata, 0);
        check("R10", "disabled", port_state, S_DIS);
        check("R12", "detach flag", sts_rdata, 2'b01);
        count_sof(2 * PFS, n);
        check("R10", "no sof after detach", n, 0);
        check("R13", "released when disabled", line_state, L_REL);

        // R11: end-of-frame error drops the port
        bring_up();
        repeat (7) @(negedge clk);
        eoferr_evt = 1'b1;
        @(negedge clk);
        eoferr_evt = 1'b0;
        @(negedge clk);
        check("R11", "enable cleared", ctl_rdata, 0);
        check("R11", "disabled", port_state, S_DIS);
        check("R12", "both flags", sts_rdata, 2'b11);
        count_sof(2 * PFS, n);
        check("R11", "no sof after eoferr", n, 0);

        // R12: write-one-to-clear and set-wins
        sts_wdata = 2'b10;
        sts_we = 1'b1;
        @(negedge clk);
        sts_we = 1'b0;
        check("R12", "clear eof flag only", sts_rdata, 2'b01);
        sts_wdata = 2'b01;
        sts_we = 1'b1;
        detach_evt = 1'b1;
        @(negedge clk);
        sts_we = 1'b0;
        detach_evt = 1'b0;
        check("R12", "set wins over clear", sts_rdata, 2'b01);
        sts_wdata = 2'b11;
        sts_we = 1'b1;
        @(negedge clk);
        sts_we = 1'b0;
        check("R12", "all cleared", sts_rdata, 2'b00);
        eoferr_evt = 1'b1;
        @(negedge clk);
        eoferr_evt = 1'b0;
        check("R12", "flag set while disabled", sts_rdata, 2'b10);
        check("R12", "ctl untouched", ctl_rdata, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule